// File: doc/BRIEF.md
# Quadrature Position Tracker with Host Capture

This block tracks the position of one motion axis from an incremental encoder. The two phase signals and the once-per-turn marker enter from outside the clock domain, so they pass through a two-stage synchronizer first. A small decoder compares each synchronized phase pair with the pair from the previous cycle and emits one up pulse, one down pulse or an illegal-move pulse. A wrapping up/down counter follows those pulses.

The host reads position at its own servo rate. It does not read the live counter. Instead it raises a one-cycle capture strobe, and the block copies the counter into a capture register. The value the host then reads stays coherent however fast the encoder moves. A rising edge on the marker input stores the count in a separate marker register and raises a marker-seen flag. Any move in which both phases change at once is treated as a fault: it is not counted, and it raises a sticky error flag. The host clears each flag with its own clear input.

Top module: `quad_pos_tracker`

## Requirements
- R1: After the synchronous reset, which is active-high, `cur_count`, `cap_value` and `idx_value` are zero and `quad_err` and `idx_seen` are low, provided the phases are held at {A,B}=00.
- R2: Each single-phase step through the forward order {A,B} = 00→10→11→01→00 raises `cur_count` by one. In this order A leads B.
- R3: Each single-phase step in the reverse order {A,B} = 00→01→11→10→00 lowers `cur_count` by one.
- R4: When both A and B change between two synchronized samples, `cur_count` is unchanged and `quad_err` goes high. `quad_err` stays high through later legal steps until `err_clr` is asserted.
- R5: `cur_count` wraps modulo 2^W. A down step from 0 gives 2^W−1, and an up step from 2^W−1 gives 0.
- R6: `cap_value` takes the value of `cur_count` on a cycle where `cap_strobe` is high. On all other cycles it holds its value.
- R7: When `cap_strobe` is high on the same clock edge at which `cur_count` steps, `cap_value` receives the count from before the step.
- R8: A rising edge on `enc_idx` copies `cur_count` into `idx_value` and sets `idx_seen`. While `enc_idx` stays high, later counts do not change `idx_value`.
- R9: `idx_clr` clears `idx_seen`.
- R10: A phase change applied before clock edge n shows up in `cur_count` at edge n+3. Two edges go to the synchronizer, one to the decoder register and one to the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| enc_idx | input | 1 | Encoder once-per-turn marker, asynchronous |
| cap_strobe | input | 1 | Host request to capture the count |
| err_clr | input | 1 | Clears the illegal-move flag |
| idx_clr | input | 1 | Clears the marker-seen flag |
| cur_count | output | W | Live position count |
| cap_value | output | W | Count captured on the last strobe |
| idx_value | output | W | Count at the last marker rising edge |
| idx_seen | output | 1 | Marker edge has occurred since the last clear |
| quad_err | output | 1 | Illegal move has occurred since the last clear |

## Verification
Two functions can act on the same clock edge: a host capture and a counter step. The bench applies a forward phase step. It then counts three falling edges, raises the strobe, and checks that the strobe is sampled on exactly the edge where the counter advances. It compares `cap_value` with the count before the step and `cur_count` with the count after it. All sixteen pairs of previous and next phase states are swept, and the expected count and error flag are computed from the phase-order distance.

// File: rtl/qpt_pkg.sv
package qpt_pkg;
  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_UP   = 2'd1,
    MV_DOWN = 2'd2,
    MV_BAD  = 2'd3
  } qpt_move_e;

  // Classify the move from the previous phase pair to the new one.
  function automatic qpt_move_e qpt_classify(input logic pa, input logic pb,
                                             input logic na, input logic nb);
    logic [1:0] chg;
    chg = {pa ^ na, pb ^ nb};
    if (chg == 2'b00)      return MV_NONE;
    else if (chg == 2'b11) return MV_BAD;
    else if (pb ^ na)      return MV_UP;
    else                   return MV_DOWN;
  endfunction
endpackage

// File: rtl/qpt_sync.sv
module qpt_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stage_q [STAGES];

  always_ff @(posedge clk) stage_q[0] <= din;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qpt_decode.sv
module qpt_decode
  import qpt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic a_s,
  input  logic b_s,
  output logic up,
  output logic dn,
  output logic bad
);
  logic      a_q, b_q;
  qpt_move_e mv;

  assign mv = qpt_classify(a_q, b_q, a_s, b_s);

  always_ff @(posedge clk) begin
    // Track the phases during reset so the first sample is not judged.
    a_q <= a_s;
    b_q <= b_s;
    if (rst) begin
      up  <= 1'b0;
      dn  <= 1'b0;
      bad <= 1'b0;
    end else begin
      up  <= (mv == MV_UP);
      dn  <= (mv == MV_DOWN);
      bad <= (mv == MV_BAD);
    end
  end
endmodule

// File: rtl/qpt_counter.sv
module qpt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up,
  input  logic         dn,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)     count <= '0;
    else if (up) count <= count + ONE;
    else if (dn) count <= count - ONE;
  end
endmodule

// File: rtl/quad_pos_tracker.sv
module quad_pos_tracker #(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enc_a,
  input  logic         enc_b,
  input  logic         enc_idx,
  input  logic         cap_strobe,
  input  logic         err_clr,
  input  logic         idx_clr,
  output logic [W-1:0] cur_count,
  output logic [W-1:0] cap_value,
  output logic [W-1:0] idx_value,
  output logic         idx_seen,
  output logic         quad_err
);
  localparam int NIN = 3;

  logic [NIN-1:0] raw_in, syn_in;
  logic           up, dn, bad;
  logic           idx_q, idx_rise;

  assign raw_in = {enc_idx, enc_b, enc_a};

  qpt_sync #(.N(NIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .din  (raw_in),
    .dout (syn_in)
  );

  qpt_decode u_dec (
    .clk (clk),
    .rst (rst),
    .a_s (syn_in[0]),
    .b_s (syn_in[1]),
    .up  (up),
    .dn  (dn),
    .bad (bad)
  );

  qpt_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .up    (up),
    .dn    (dn),
    .count (cur_count)
  );

  assign idx_rise = syn_in[2] & ~idx_q;

  always_ff @(posedge clk) begin
    idx_q <= syn_in[2];
    if (rst) begin
      cap_value <= '0;
      idx_value <= '0;
      idx_seen  <= 1'b0;
      quad_err  <= 1'b0;
    end else begin
      // Both registers sample the counter before this edge's step.
      if (cap_strobe) cap_value <= cur_count;
      if (idx_rise)   idx_value <= cur_count;
      if (idx_rise)      idx_seen <= 1'b1;
      else if (idx_clr)  idx_seen <= 1'b0;
      if (bad)           quad_err <= 1'b1;
      else if (err_clr)  quad_err <= 1'b0;
    end
  end
endmodule

module quad_pos_tracker_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         cap_strobe,
  input logic         err_clr,
  input logic         idx_clr,
  input logic [W-1:0] cur_count,
  input logic [W-1:0] cap_value,
  input logic         idx_seen,
  input logic         quad_err
);
  localparam logic [W-1:0] ONE = W'(1);

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cur_count == $past(cur_count) || cur_count == $past(cur_count) + ONE
              || cur_count == $past(cur_count) - ONE)); // R2
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap_strobe |=> $stable(cap_value)); // R6
  AST_CAP_PRE: assert property (@(posedge clk) disable iff (rst)
    cap_strobe |=> cap_value == $past(cur_count)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (quad_err && !err_clr) |=> quad_err); // R4
  AST_IDX_STICKY: assert property (@(posedge clk) disable iff (rst)
    (idx_seen && !idx_clr) |=> idx_seen); // R8
endmodule

bind quad_pos_tracker quad_pos_tracker_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cap_strobe (cap_strobe),
  .err_clr    (err_clr),
  .idx_clr    (idx_clr),
  .cur_count  (cur_count),
  .cap_value  (cap_value),
  .idx_seen   (idx_seen),
  .quad_err   (quad_err)
);

// File: tb/test_quad_pos_tracker.sv
`timescale 1ns/1ps
module test_quad_pos_tracker;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst, enc_a, enc_b, enc_idx, cap_strobe, err_clr, idx_clr;
  logic [W-1:0] cur_count, cap_value, idx_value;
  logic idx_seen, quad_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [W-1:0] exp_cnt = '0;
  logic         exp_err = 1'b0;

  always #5 clk = ~clk;

  quad_pos_tracker #(.W(W)) i_quad_pos_tracker (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .cap_strobe(cap_strobe), .err_clr(err_clr), .idx_clr(idx_clr),
    .cur_count(cur_count), .cap_value(cap_value), .idx_value(idx_value),
    .idx_seen(idx_seen), .quad_err(quad_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Position of {A,B} in the forward order 00,10,11,01.
  function automatic int phase_pos(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] pos_ab(input int p);
    case (p % 4)
      0:       return 2'b00;
      1:       return 2'b10;
      2:       return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  task automatic step(input string tag, input logic na, input logic nb);
    int d;
    d = (phase_pos(na, nb) - phase_pos(enc_a, enc_b) + 4) % 4;
    @(negedge clk);
    enc_a = na;
    enc_b = nb;
    repeat (5) @(negedge clk);
    if (d == 1) exp_cnt = exp_cnt + 1'b1;
    if (d == 3) exp_cnt = exp_cnt - 1'b1;
    if (d == 2) exp_err = 1'b1;
    check({tag, " count"}, 32'(cur_count), 32'(exp_cnt));
    check({tag, " err"}, 32'(quad_err), 32'(exp_err));
  endtask

  task automatic fwd(input string tag);
    logic [1:0] ab;
    ab = pos_ab(phase_pos(enc_a, enc_b) + 1);
    step(tag, ab[1], ab[0]);
  endtask

  task automatic rev(input string tag);
    logic [1:0] ab;
    ab = pos_ab(phase_pos(enc_a, enc_b) + 3);
    step(tag, ab[1], ab[0]);
  endtask

  task automatic clear_err;
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    exp_err = 1'b0;
    check("R4 err_clr", 32'(quad_err), 32'd0);
  endtask

  task automatic capture;
    @(negedge clk); cap_strobe = 1'b1;
    @(negedge clk); cap_strobe = 1'b0;
    check("R6 capture", 32'(cap_value), 32'(exp_cnt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] old;
    rst = 1'b1; enc_a = 1'b0; enc_b = 1'b0; enc_idx = 1'b0;
    cap_strobe = 1'b0; err_clr = 1'b0; idx_clr = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 count", 32'(cur_count), 32'd0);
    check("R1 cap", 32'(cap_value), 32'd0);
    check("R1 idx", 32'(idx_value), 32'd0);
    check("R1 seen", 32'(idx_seen), 32'd0);
    check("R1 err", 32'(quad_err), 32'd0);

    // R2/R3/R4: every previous/next phase pair.
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        logic [1:0] ab;
        while (phase_pos(enc_a, enc_b) != f) fwd("R2 walk");
        ab = pos_ab(t);
        step("R2/R3/R4 sweep", ab[1], ab[0]);
        if (exp_err) begin
          fwd("R4 sticky");
          check("R4 sticky after legal step", 32'(quad_err), 32'd1);
          clear_err();
        end
      end
    end
    for (int k = 0; k < 4; k++) rev("R3 reverse run");

    // R5: wrap both ways.
    while (exp_cnt != '0) rev("R5 walk");
    rev("R5 down wrap");
    check("R5 down wrap value", 32'(cur_count), 32'((1 << W) - 1));
    fwd("R5 up wrap");
    check("R5 up wrap value", 32'(cur_count), 32'd0);

    // R6: capture and hold.
    fwd("R6 setup"); fwd("R6 setup");
    capture();
    old = exp_cnt;
    fwd("R6 move"); fwd("R6 move");
    check("R6 hold without strobe", 32'(cap_value), 32'(old));

    // R7/R10: strobe on the edge where the counter steps.
    old = exp_cnt;
    @(negedge clk);
    begin
      logic [1:0] ab;
      ab = pos_ab(phase_pos(enc_a, enc_b) + 1);
      enc_a = ab[1]; enc_b = ab[0];
    end
    repeat (3) @(negedge clk);
    check("R10 count not yet stepped", 32'(cur_count), 32'(old));
    cap_strobe = 1'b1;
    @(negedge clk);
    cap_strobe = 1'b0;
    exp_cnt = old + 1'b1;
    check("R10 count stepped at third edge", 32'(cur_count), 32'(exp_cnt));
    check("R7 pre-step capture", 32'(cap_value), 32'(old));

    // R8/R9: marker handling.
    @(negedge clk); enc_idx = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 idx latch", 32'(idx_value), 32'(exp_cnt));
    check("R8 idx seen", 32'(idx_seen), 32'd1);
    old = exp_cnt;
    fwd("R8 move while high");
    check("R8 no relatch while high", 32'(idx_value), 32'(old));
    @(negedge clk); idx_clr = 1'b1;
    @(negedge clk); idx_clr = 1'b0;
    check("R9 seen cleared", 32'(idx_seen), 32'd0);
    @(negedge clk); enc_idx = 1'b0;
    rev("R8 move while low");
    @(negedge clk); enc_idx = 1'b1;
    repeat (4) @(negedge clk);
    check("R8 second latch", 32'(idx_value), 32'(exp_cnt));
    check("R8 seen again", 32'(idx_seen), 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule